// File: doc/BRIEF.md
# Calendar Clock Decimal Digit Formatter

This block turns a snapshot of calendar time into a short stream of decimal digit characters. It takes a month index, day of month, hour, minute, second and a free-running interval counter, all in binary. When a read strobe arrives it samples all of them together. The counter is reduced modulo 60 so that it gives a sub-second field. The block then sends twelve 6-bit characters, one per cycle.

Each field becomes two decimal digits, and the tens digit goes first. The character code has a special value for zero: the digit zero never appears as binary 0 on the output. The caller gives the size of its receiving buffer with each strobe. The block answers with a length of twelve, or with zero if the buffer is too small; in that case it sends nothing.

Top module: `cal_digit_fmt`

## Requirements
- R1: The twelve characters are sent in this field order: month, day of month, hour, minute, second, interval counter modulo 60.
- R2: Each field value (0 to 99) is sent as two characters, the tens digit first and then the units digit.
- R3: A digit of value zero is sent as character code 10 (octal 12). Digits 1 to 9 are sent as their binary value in the 6-bit character. No character is ever 0, and none is above 10.
- R4: The month input is an index from 0 to 11, and the month field is sent as that index plus one (1 to 12).
- R5: The sixth field is the interval counter value modulo 60, taken at the strobe.
- R6: A strobe taken while idle gives `len_vld` for exactly one cycle, in the cycle after the strobe edge. `len` is 12 if `buf_size` is at least 12, and 0 otherwise. An accepted request puts its first character on the output in that same cycle, followed by one character per cycle with no gaps. A rejected request sends no characters.
- R7: All six fields are sampled in the strobe cycle. Changes on the field inputs during streaming do not alter the characters sent.
- R8: `done` is high together with the twelfth character, and at no other time.
- R9: A strobe that arrives while a stream is in progress is ignored. It produces no `len_vld`, and the current stream goes on unchanged.
- R10: After reset, `char_vld`, `done` and `len_vld` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_req | input | 1 | Read strobe, one cycle |
| buf_size | input | BUF_W (8) | Size of the receiving buffer offered with the strobe |
| mon_idx | input | 7 | Month index, 0 to 11 |
| mday | input | 7 | Day of month, binary |
| hour | input | 7 | Hour, binary |
| minute | input | 7 | Minute, binary |
| second | input | 7 | Second, binary |
| ivl_cnt | input | CNT_W (16) | Free-running interval counter |
| len_vld | output | 1 | Reported length is valid |
| len | output | 4 | Reported length, 12 or 0 |
| char_vld | output | 1 | Character output is valid |
| char_out | output | 6 | Digit character |
| done | output | 1 | Last character of the stream |

## Verification
On every cycle, the assertions check these properties:
- every valid character is in the range 1 to 10;
- `done` only appears with a valid character;
- a stream advances one position per cycle;
- the sampled fields stay still during a stream;
- a reported length is either 12 followed by streaming, or 0 with no stream;
- no length is reported while a stream is busy.

Only the bench scenarios can show that the characters carry the right digits in the right order. These scenarios cover fields with zero digits (10, 00, 30), the month offset, counter values at and above 60, the exact-size and short buffer cases, and input changes and ignored strobes in the middle of a stream.

// File: rtl/cal_fmt_pkg.sv
package cal_fmt_pkg;
  localparam int FLD_W      = 7;
  localparam int CHAR_W     = 6;
  localparam int NUM_FIELDS = 6;
  localparam int NUM_CHARS  = 2 * NUM_FIELDS;
  localparam int IDX_W      = $clog2(NUM_CHARS);
  localparam int LEN_W      = $clog2(NUM_CHARS + 1);
  localparam logic [CHAR_W-1:0] ZERO_CHAR = 6'o12;

  typedef logic [NUM_FIELDS-1:0][FLD_W-1:0]  fld_arr_t;
  typedef logic [NUM_CHARS-1:0][CHAR_W-1:0]  char_arr_t;
endpackage

// File: rtl/cal_digit_split.sv
module cal_digit_split
  import cal_fmt_pkg::*;
(
  input  logic [FLD_W-1:0]  val,
  output logic [CHAR_W-1:0] tens_ch,
  output logic [CHAR_W-1:0] units_ch
);
  logic [FLD_W-1:0] tens_v;
  logic [FLD_W-1:0] units_v;

  // constant divider, valid for values 0..99
  always_comb begin
    tens_v  = val / FLD_W'(10);
    units_v = val % FLD_W'(10);
  end

  always_comb begin
    tens_ch  = (tens_v  == '0) ? ZERO_CHAR : CHAR_W'(tens_v);
    units_ch = (units_v == '0) ? ZERO_CHAR : CHAR_W'(units_v);
  end
endmodule

// File: rtl/cal_fmt_seq.sv
module cal_fmt_seq
  import cal_fmt_pkg::*;
#(
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [BUF_W-1:0] buf_size,
  input  fld_arr_t         fld_in,
  output fld_arr_t         fld_q,
  output logic             busy_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             last_char,
  output logic             len_vld_q,
  output logic [LEN_W-1:0] len_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHARS - 1);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NUM_CHARS);

  logic             fits;
  logic             accept;
  logic             reject;
  logic             busy_d;
  logic [IDX_W-1:0] idx_d;
  logic             len_vld_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    fits      = (32'(buf_size) >= NUM_CHARS);
    accept    = rd_req & ~busy_q & fits;
    reject    = rd_req & ~busy_q & ~fits;
    last_char = busy_q & (idx_q == LAST_IDX);
    busy_d    = accept | (busy_q & ~last_char);
    if (accept)      idx_d = '0;
    else if (busy_q) idx_d = idx_q + IDX_W'(1);
    else             idx_d = idx_q;
    len_vld_d = accept | reject;
    len_d     = accept ? FULL_LEN : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      len_vld_q <= 1'b0;
      len_q     <= '0;
    end else begin
      busy_q    <= busy_d;
      idx_q     <= idx_d;
      len_vld_q <= len_vld_d;
      len_q     <= len_d;
    end
  end

  // field capture, enabled only by an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (accept) begin
      fld_q <= fld_in;
    end
  end

  AST_LEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    len_vld_q |-> (len_q == FULL_LEN || len_q == '0)); // R6
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_vld_q && len_q == FULL_LEN) |-> (busy_q && idx_q == '0)); // R6
  AST_SHORT_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (len_vld_q && len_q == '0) |-> !busy_q); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_char) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1))); // R8
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_char) |=> !len_vld_q); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(fld_q)); // R7
endmodule

// File: rtl/cal_digit_fmt.sv
module cal_digit_fmt
  import cal_fmt_pkg::*;
#(
  parameter int BUF_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [BUF_W-1:0]    buf_size,
  input  logic [FLD_W-1:0]    mon_idx,
  input  logic [FLD_W-1:0]    mday,
  input  logic [FLD_W-1:0]    hour,
  input  logic [FLD_W-1:0]    minute,
  input  logic [FLD_W-1:0]    second,
  input  logic [CNT_W-1:0]    ivl_cnt,
  output logic                len_vld,
  output logic [LEN_W-1:0]    len,
  output logic                char_vld,
  output logic [CHAR_W-1:0]   char_out,
  output logic                done
);
  localparam logic [CNT_W-1:0] CNT_MOD = CNT_W'(60);

  logic             rst_meta_q;
  logic             rst_sync_q;
  fld_arr_t         fld_in;
  fld_arr_t         fld_q;
  char_arr_t        chars;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_char;
  logic [FLD_W-1:0] cnt_mod;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // field order on the wire: month, day, hour, minute, second, counter
  always_comb begin
    cnt_mod   = FLD_W'(ivl_cnt % CNT_MOD);
    fld_in[0] = mon_idx + FLD_W'(1);
    fld_in[1] = mday;
    fld_in[2] = hour;
    fld_in[3] = minute;
    fld_in[4] = second;
    fld_in[5] = cnt_mod;
  end

  cal_fmt_seq #(.BUF_W(BUF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .rd_req    (rd_req),
    .buf_size  (buf_size),
    .fld_in    (fld_in),
    .fld_q     (fld_q),
    .busy_q    (busy_q),
    .idx_q     (idx_q),
    .last_char (last_char),
    .len_vld_q (len_vld),
    .len_q     (len)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_split
    cal_digit_split u_split (
      .val      (fld_q[g]),
      .tens_ch  (chars[2*g]),
      .units_ch (chars[2*g+1])
    );
  end

  always_comb begin
    char_vld = busy_q;
    char_out = busy_q ? chars[idx_q] : '0;
    done     = last_char;
  end

  AST_CHAR_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    char_vld |-> (char_out != '0 && char_out <= ZERO_CHAR)); // R3
  AST_DONE_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> char_vld); // R8
endmodule

// File: tb/cal_digit_fmt_tb.sv
module cal_digit_fmt_tb;
  logic        clk;
  logic        rst_n;
  logic        rd_req;
  logic [7:0]  buf_size;
  logic [6:0]  mon_idx, mday, hour, minute, second;
  logic [15:0] ivl_cnt;
  logic        len_vld;
  logic [3:0]  len;
  logic        char_vld;
  logic [5:0]  char_out;
  logic        done;

  int errors = 0;
  int checks = 0;
  logic [6:0] exp_q[$];   // {last, char}
  string tag = "R1/R2/R3";

  cal_digit_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .buf_size(buf_size),
    .mon_idx(mon_idx), .mday(mday), .hour(hour), .minute(minute),
    .second(second), .ivl_cnt(ivl_cnt), .len_vld(len_vld), .len(len),
    .char_vld(char_vld), .char_out(char_out), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [5:0] enc(int d);
    return (d == 0) ? 6'd10 : 6'(d);
  endfunction

  task automatic push_field(int v, bit last_f);
    exp_q.push_back({1'b0, enc(v / 10)});
    exp_q.push_back({last_f, enc(v % 10)});
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop and compare each produced character
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (char_vld) begin
          if (exp_q.size() == 0) begin
            check({"R6 unexpected char ", tag}, 1, 0);
          end else begin
            logic [6:0] e;
            e = exp_q.pop_front();
            check({"char ", tag}, char_out, e[5:0]);
            check("R8 done with char", done, e[6]);
          end
        end else begin
          if (done) check("R8 done without char", 1, 0);
        end
      end
    end
  end

  task automatic run_read(int mi, int md, int hr, int mn, int sc, int cnt,
                          int bsz, bit poke);
    bit ok;
    ok = (bsz >= 12);
    if (ok) begin
      // R4 month plus one, R5 counter modulo 60
      push_field(mi + 1, 0);
      push_field(md, 0);
      push_field(hr, 0);
      push_field(mn, 0);
      push_field(sc, 0);
      push_field(cnt % 60, 1);
    end
    @(negedge clk);
    rd_req = 1'b1; buf_size = 8'(bsz);
    mon_idx = 7'(mi); mday = 7'(md); hour = 7'(hr);
    minute = 7'(mn); second = 7'(sc); ivl_cnt = 16'(cnt);
    @(negedge clk);
    rd_req = 1'b0;
    check("R6 len_vld", len_vld, 1);
    check("R6 len", len, ok ? 12 : 0);
    // R7 scramble inputs during streaming
    mon_idx = 7'd3; mday = 7'd44; hour = 7'd55; minute = 7'd66;
    second = 7'd77; ivl_cnt = 16'd1234;
    if (poke) begin
      rd_req = 1'b1; buf_size = 8'd50;
      @(negedge clk);
      rd_req = 1'b0;
      check("R9 ignored strobe len_vld", len_vld, 0);
      @(negedge clk);
      check("R9 ignored strobe len_vld later", len_vld, 0);
    end
    if (!ok) begin
      @(negedge clk);
      check("R6 short buffer char_vld", char_vld, 0);
      check("R6 short buffer len_vld one cycle", len_vld, 0);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0; rd_req = 1'b0; buf_size = '0;
    mon_idx = '0; mday = '0; hour = '0; minute = '0; second = '0; ivl_cnt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset char_vld", char_vld, 0);
    check("R10 reset done", done, 0);
    check("R10 reset len_vld", len_vld, 0);

    tag = "R1/R2/R3 zeros 10 00 30";
    run_read(9, 20, 0, 0, 30, 125, 200, 0);
    tag = "R4/R5 month 01 counter 60";
    run_read(0, 31, 23, 59, 59, 60, 100, 0);
    tag = "R7/R9 poke during stream";
    run_read(11, 9, 12, 45, 7, 65535, 12, 1);
    tag = "R6 short buffer";
    run_read(4, 5, 6, 7, 8, 9, 11, 0);
    tag = "R5 counter 119";
    run_read(1, 10, 10, 1, 0, 119, 12, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule